// File: doc/BRIEF.md
# Fully Associative Translation Buffer with Page Permissions

This block translates virtual addresses into physical addresses from a small table of recently used page mappings. Pages are 8 KB, so the low 13 address bits go through unchanged and the bits above them form the virtual page number. The table is fully associative: any mapping can occupy any slot, and every slot is compared against the request at the same time. A slot holds either one base page or one superpage. A superpage covers 16 consecutive base pages, aligned to a 16-page boundary, and maps them onto 16 consecutive physical pages.

Each slot stores four access-right bits: read and write for user mode, and read and write for kernel mode. Every lookup is checked against these bits. A lookup that fails to match any slot reports a miss. The surrounding logic then walks the page tables and writes the result through the fill port. A fill goes into the lowest-numbered empty slot. If no slot is empty, it replaces the slot that was used least recently. A flash-invalidate input empties the whole table in one cycle.

Top module: `tlb_fa`

## Requirements
- R1: When a lookup matches exactly one slot and the access is allowed, `respHit` goes high one cycle after the request. `respPa` then equals the slot's physical page number followed by the request's 13 offset bits. `respPa` is zero whenever `respHit` is low.
- R2: When a lookup matches no valid slot, `respMiss` goes high one cycle later, for that one cycle only. No response flag is asserted in a cycle that follows a cycle without a lookup.
- R3: `fillPerm` bit 0 grants user read, bit 1 grants user write, bit 2 grants kernel read and bit 3 grants kernel write (`lookupUser`=1 selects user mode, `lookupWrite`=1 selects write). If a single match lacks the needed bit, the response is `respFault` rather than `respHit`.
- R4: A superpage slot compares only the upper page-number bits, not the low 4. On a hit, the request's low 4 page-number bits replace the low 4 bits of the physical page number.
- R5: On a superpage fill, the low 4 bits of both the virtual and the physical page number are stored as zero, whatever values were driven.
- R6: A fill writes the lowest-numbered invalid slot. If every slot is valid, it replaces the least recently used slot.
- R7: A hit and a fill each make their slot the most recently used. A fault, a miss or a multiple match leaves the recency order unchanged.
- R8: `invalidateAll` clears every valid bit in one cycle. A fill presented in the same cycle is dropped.
- R9: When two or more valid slots match, only `respMulti` is raised; `respHit`, `respMiss` and `respFault` stay low.
- R10: After reset all response outputs are low and the table is empty.
- R11: A lookup issued in the same cycle as a fill sees the table as it was before that fill.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| lookupValid | input | 1 | Lookup request strobe |
| lookupVa | input | VA_W | Virtual address to translate |
| lookupWrite | input | 1 | 1 = write access, 0 = read |
| lookupUser | input | 1 | 1 = user mode, 0 = kernel mode |
| fillValid | input | 1 | Write a new mapping |
| fillVpn | input | VA_W-13 | Virtual page number of the new mapping |
| fillPpn | input | PA_W-13 | Physical page number of the new mapping |
| fillSuper | input | 1 | New mapping is a 16-page superpage |
| fillPerm | input | 4 | Access rights {kernel write, kernel read, user write, user read} |
| invalidateAll | input | 1 | Empty the whole table |
| respValid | output | 1 | A response is present this cycle |
| respHit | output | 1 | Translation found and permitted |
| respMiss | output | 1 | No slot matched |
| respFault | output | 1 | Slot matched but the access is not permitted |
| respMulti | output | 1 | More than one slot matched |
| respPa | output | PA_W | Translated physical address |

## Verification
The bench places an unaligned superpage over a range that also holds a base page. A compare that used all page-number bits would miss inside the superpage. A design that did not mask the fill values would return a corrupted physical page. A priority encoder in place of overlap detection would report a hit where the error flag is required. For recency, the bench fills a small table, touches the oldest slots and then issues a faulting access. It checks which mappings survive later fills, so a design that refreshes on faults or picks a fixed victim evicts the wrong page. Same-cycle fill and lookup, and invalidation racing a fill, check the ordering rules. A design that forwards the new mapping would hit where a miss is required, and one that lets the fill win would leave a stale entry behind.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

  localparam int PAGE_OFF_W = 13;
  localparam int SUPER_BITS = 4;
  localparam int PERM_W     = 4;

  // Strobes from control to datapath
  typedef struct packed {
    logic clearAll;
    logic writeEn;
    logic touchEn;
  } tlbStrobes_t;

  // perm bit index = {kernel, write}: 0 user read, 1 user write,
  // 2 kernel read, 3 kernel write
  function automatic logic permAllows(input logic [PERM_W-1:0] perm,
                                      input logic user,
                                      input logic write);
    return perm[{~user, write}];
  endfunction

endpackage

// File: rtl/tlb_datapath.sv
module tlb_datapath
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 128,
  parameter int IDX_W   = 7,
  parameter int VPN_W   = 19,
  parameter int PPN_W   = 19
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  tlbStrobes_t              strobes,
  input  logic [IDX_W-1:0]         writeIdx,
  input  logic                     lookupValid,
  input  logic [VPN_W-1:0]         lookupVpn,
  input  logic [PAGE_OFF_W-1:0]    lookupOff,
  input  logic                     lookupWrite,
  input  logic                     lookupUser,
  input  logic [VPN_W-1:0]         fillVpn,
  input  logic [PPN_W-1:0]         fillPpn,
  input  logic                     fillSuper,
  input  logic [PERM_W-1:0]        fillPerm,
  output logic [ENTRIES-1:0]       validVec,
  output logic                     matchOne,
  output logic                     permOk,
  output logic [IDX_W-1:0]         hitIdx,
  output logic                     respValid,
  output logic                     respHit,
  output logic                     respMiss,
  output logic                     respFault,
  output logic                     respMulti,
  output logic [PPN_W+PAGE_OFF_W-1:0] respPa
);

  localparam int CNT_W = IDX_W + 1;

  logic [VPN_W-1:0]  vpnTag  [ENTRIES];
  logic [PPN_W-1:0]  ppnVal  [ENTRIES];
  logic [PERM_W-1:0] permVal [ENTRIES];
  logic [ENTRIES-1:0] superVec;
  logic [ENTRIES-1:0] matchVec;

  logic [CNT_W-1:0] matchCount;
  logic             matchNone;
  logic             matchMany;
  logic [PPN_W-1:0] hitPpn;

  // Parallel compare, one comparator per slot
  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    always_comb begin
      if (superVec[g])
        matchVec[g] = validVec[g] &&
          (lookupVpn[VPN_W-1:SUPER_BITS] == vpnTag[g][VPN_W-1:SUPER_BITS]);
      else
        matchVec[g] = validVec[g] && (lookupVpn == vpnTag[g]);
    end
  end

  always_comb begin
    matchCount = '0;
    hitIdx     = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      matchCount = matchCount + CNT_W'(matchVec[i]);
      if (matchVec[i]) hitIdx = IDX_W'(i);
    end
  end

  assign matchNone = (matchCount == '0);
  assign matchOne  = (matchCount == CNT_W'(1));
  assign matchMany = !matchNone && !matchOne;
  assign permOk    = permAllows(permVal[hitIdx], lookupUser, lookupWrite);

  always_comb begin
    hitPpn = ppnVal[hitIdx];
    if (superVec[hitIdx])
      hitPpn[SUPER_BITS-1:0] = lookupVpn[SUPER_BITS-1:0];
  end

  // Valid bits
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      validVec <= '0;
    end else if (strobes.clearAll) begin
      validVec <= '0;
    end else if (strobes.writeEn) begin
      validVec[writeIdx] <= 1'b1;
    end
  end

  // Slot contents; superpages stored aligned
  always_ff @(posedge clk) begin
    if (strobes.writeEn) begin
      superVec[writeIdx] <= fillSuper;
      permVal[writeIdx]  <= fillPerm;
      if (fillSuper) begin
        vpnTag[writeIdx] <= {fillVpn[VPN_W-1:SUPER_BITS], {SUPER_BITS{1'b0}}};
        ppnVal[writeIdx] <= {fillPpn[PPN_W-1:SUPER_BITS], {SUPER_BITS{1'b0}}};
      end else begin
        vpnTag[writeIdx] <= fillVpn;
        ppnVal[writeIdx] <= fillPpn;
      end
    end
  end

  // Registered response
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      respValid <= 1'b0;
      respHit   <= 1'b0;
      respMiss  <= 1'b0;
      respFault <= 1'b0;
      respMulti <= 1'b0;
      respPa    <= '0;
    end else begin
      respValid <= lookupValid;
      respHit   <= lookupValid && matchOne && permOk;
      respMiss  <= lookupValid && matchNone;
      respFault <= lookupValid && matchOne && !permOk;
      respMulti <= lookupValid && matchMany;
      respPa    <= (lookupValid && matchOne && permOk) ? {hitPpn, lookupOff} : '0;
    end
  end

  // R9: exactly one outcome per response
  p_one_outcome_r9: assert property (@(posedge clk) disable iff (!rstN)
    respValid |-> $onehot({respHit, respMiss, respFault, respMulti}));

  // R1: address only on hit
  p_pa_only_on_hit_r1: assert property (@(posedge clk) disable iff (!rstN)
    !respHit |-> (respPa == '0));

  // R2: a request is answered next cycle
  p_req_answered_r2: assert property (@(posedge clk) disable iff (!rstN)
    lookupValid |=> respValid);

  // R2: no outcome without a request
  p_quiet_when_idle_r2: assert property (@(posedge clk) disable iff (!rstN)
    !lookupValid |=> !(respHit || respMiss || respFault || respMulti));

  // R8: flash invalidate empties the table
  p_clear_all_r8: assert property (@(posedge clk) disable iff (!rstN)
    strobes.clearAll |=> (validVec == '0));

  // R5: superpage tags stored aligned
  p_super_aligned_r5: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.writeEn && fillSuper) |=>
      (vpnTag[$past(writeIdx)][SUPER_BITS-1:0] == '0));

endmodule

// File: rtl/tlb_ctrl.sv
module tlb_ctrl
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 128,
  parameter int IDX_W   = 7
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               lookupValid,
  input  logic               fillValid,
  input  logic               invalidateAll,
  input  logic [ENTRIES-1:0] validVec,
  input  logic               matchOne,
  input  logic               permOk,
  input  logic [IDX_W-1:0]   hitIdx,
  output tlbStrobes_t        strobes,
  output logic [IDX_W-1:0]   writeIdx
);

  localparam logic [IDX_W-1:0] OLDEST = IDX_W'(ENTRIES - 1);

  // age 0 = most recent, ENTRIES-1 = least recent; always a permutation
  logic [ENTRIES-1:0][IDX_W-1:0] ages;
  logic [ENTRIES-1:0]            lruVec;
  logic [IDX_W-1:0]              lruIdx;
  logic [IDX_W-1:0]              touchIdx;
  logic [IDX_W-1:0]              touchAge;
  logic                          hitNow;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_old
    assign lruVec[g] = (ages[g] == OLDEST);
  end

  always_comb begin
    lruIdx = '0;
    for (int i = 0; i < ENTRIES; i++)
      if (lruVec[i]) lruIdx = IDX_W'(i);
  end

  // Lowest invalid slot wins, otherwise the oldest
  always_comb begin
    writeIdx = lruIdx;
    for (int i = ENTRIES - 1; i >= 0; i--)
      if (!validVec[i]) writeIdx = IDX_W'(i);
  end

  assign hitNow           = lookupValid && matchOne && permOk;
  assign strobes.clearAll = invalidateAll;
  assign strobes.writeEn  = fillValid && !invalidateAll;
  assign strobes.touchEn  = strobes.writeEn || hitNow;
  assign touchIdx         = strobes.writeEn ? writeIdx : hitIdx;
  assign touchAge         = ages[touchIdx];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < ENTRIES; i++) ages[i] <= IDX_W'(i);
    end else if (strobes.touchEn) begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (IDX_W'(i) == touchIdx)
          ages[i] <= '0;
        else if (ages[i] < touchAge)
          ages[i] <= ages[i] + IDX_W'(1);
      end
    end
  end

  // R6: exactly one oldest slot
  p_single_oldest_r6: assert property (@(posedge clk) disable iff (!rstN)
    $onehot(lruVec));

  // R7: touched slot becomes most recent
  p_touch_is_newest_r7: assert property (@(posedge clk) disable iff (!rstN)
    strobes.touchEn |=> (ages[$past(touchIdx)] == '0));

  // R7: order frozen without hit or fill
  p_order_frozen_r7: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.touchEn |=> $stable(ages));

  // R8: fill dropped under invalidate
  p_clear_blocks_fill_r8: assert property (@(posedge clk) disable iff (!rstN)
    invalidateAll |-> !strobes.writeEn);

endmodule

// File: rtl/tlb_fa.sv
module tlb_fa
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 128,
  parameter int VA_W    = 32,
  parameter int PA_W    = 32
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       lookupValid,
  input  logic [VA_W-1:0]            lookupVa,
  input  logic                       lookupWrite,
  input  logic                       lookupUser,
  input  logic                       fillValid,
  input  logic [VA_W-PAGE_OFF_W-1:0] fillVpn,
  input  logic [PA_W-PAGE_OFF_W-1:0] fillPpn,
  input  logic                       fillSuper,
  input  logic [PERM_W-1:0]          fillPerm,
  input  logic                       invalidateAll,
  output logic                       respValid,
  output logic                       respHit,
  output logic                       respMiss,
  output logic                       respFault,
  output logic                       respMulti,
  output logic [PA_W-1:0]            respPa
);

  localparam int IDX_W = $clog2(ENTRIES);
  localparam int VPN_W = VA_W - PAGE_OFF_W;
  localparam int PPN_W = PA_W - PAGE_OFF_W;

  tlbStrobes_t        strobes;
  logic [IDX_W-1:0]   writeIdx;
  logic [IDX_W-1:0]   hitIdx;
  logic [ENTRIES-1:0] validVec;
  logic               matchOne;
  logic               permOk;

  tlb_ctrl #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .lookupValid(lookupValid), .fillValid(fillValid),
    .invalidateAll(invalidateAll), .validVec(validVec),
    .matchOne(matchOne), .permOk(permOk), .hitIdx(hitIdx),
    .strobes(strobes), .writeIdx(writeIdx)
  );

  tlb_datapath #(.ENTRIES(ENTRIES), .IDX_W(IDX_W),
                 .VPN_W(VPN_W), .PPN_W(PPN_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .writeIdx(writeIdx),
    .lookupValid(lookupValid),
    .lookupVpn(lookupVa[VA_W-1:PAGE_OFF_W]),
    .lookupOff(lookupVa[PAGE_OFF_W-1:0]),
    .lookupWrite(lookupWrite), .lookupUser(lookupUser),
    .fillVpn(fillVpn), .fillPpn(fillPpn), .fillSuper(fillSuper),
    .fillPerm(fillPerm),
    .validVec(validVec), .matchOne(matchOne), .permOk(permOk),
    .hitIdx(hitIdx),
    .respValid(respValid), .respHit(respHit), .respMiss(respMiss),
    .respFault(respFault), .respMulti(respMulti), .respPa(respPa)
  );

endmodule

// File: tb/sim_tlb_fa.sv
`timescale 1ns/1ps
module sim_tlb_fa;

  localparam int ENTRIES = 8;
  localparam int VA_W = 32;
  localparam int PA_W = 32;
  localparam int OFF  = 13;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic lookupValid = 1'b0;
  logic [VA_W-1:0] lookupVa = '0;
  logic lookupWrite = 1'b0;
  logic lookupUser = 1'b0;
  logic fillValid = 1'b0;
  logic [VA_W-OFF-1:0] fillVpn = '0;
  logic [PA_W-OFF-1:0] fillPpn = '0;
  logic fillSuper = 1'b0;
  logic [3:0] fillPerm = '0;
  logic invalidateAll = 1'b0;
  logic respValid, respHit, respMiss, respFault, respMulti;
  logic [PA_W-1:0] respPa;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  tlb_fa #(.ENTRIES(ENTRIES), .VA_W(VA_W), .PA_W(PA_W)) u0 (
    .clk(clk), .rstN(rstN),
    .lookupValid(lookupValid), .lookupVa(lookupVa),
    .lookupWrite(lookupWrite), .lookupUser(lookupUser),
    .fillValid(fillValid), .fillVpn(fillVpn), .fillPpn(fillPpn),
    .fillSuper(fillSuper), .fillPerm(fillPerm),
    .invalidateAll(invalidateAll),
    .respValid(respValid), .respHit(respHit), .respMiss(respMiss),
    .respFault(respFault), .respMulti(respMulti), .respPa(respPa)
  );

  // outcome code {hit, miss, fault, multi}
  task automatic expectResp(input string req, input logic [3:0] outc,
                            input logic [PA_W-1:0] pa);
    logic [3:0] got;
    got = {respHit, respMiss, respFault, respMulti};
    total++;
    if (got !== outc || respPa !== pa) begin
      bad++;
      $display("FAIL %s: flags=%b pa=%h expected flags=%b pa=%h",
               req, got, respPa, outc, pa);
    end
  endtask

  task automatic doFill(input logic [VA_W-OFF-1:0] vpn,
                        input logic [PA_W-OFF-1:0] ppn,
                        input logic sup, input logic [3:0] perm);
    fillValid = 1'b1; fillVpn = vpn; fillPpn = ppn;
    fillSuper = sup; fillPerm = perm;
    @(posedge clk); @(negedge clk);
    fillValid = 1'b0; fillSuper = 1'b0;
  endtask

  task automatic doLookup(input logic [VA_W-OFF-1:0] vpn,
                          input logic [OFF-1:0] off,
                          input logic wr, input logic usr);
    lookupValid = 1'b1; lookupVa = {vpn, off};
    lookupWrite = wr; lookupUser = usr;
    @(posedge clk); @(negedge clk);
    lookupValid = 1'b0;
  endtask

  task automatic doInvalidate();
    invalidateAll = 1'b1;
    @(posedge clk); @(negedge clk);
    invalidateAll = 1'b0;
  endtask

  task automatic testReset();
    expectResp("R10 reset outputs", 4'b0000, '0);
    total++;
    if (respValid !== 1'b0) begin
      bad++; $display("FAIL R10 respValid=%b expected 0", respValid);
    end
    doLookup(19'h00011, 13'h0, 1'b0, 1'b1);
    expectResp("R10 empty after reset", 4'b0100, '0);
  endtask

  task automatic testBasic();
    doFill(19'h00011, 19'h0AB12, 1'b0, 4'hF);
    doLookup(19'h00011, 13'h1F0F, 1'b0, 1'b1);
    expectResp("R1 base hit", 4'b1000, {19'h0AB12, 13'h1F0F});
    doLookup(19'h00012, 13'h0004, 1'b0, 1'b1);
    expectResp("R2 miss", 4'b0100, '0);
    @(posedge clk); @(negedge clk);
    expectResp("R2 miss lasts one cycle", 4'b0000, '0);
  endtask

  task automatic testPerm();
    doFill(19'h00020, 19'h00040, 1'b0, 4'b1100);
    doLookup(19'h00020, 13'h0010, 1'b0, 1'b1);
    expectResp("R3 user read of kernel page", 4'b0010, '0);
    doLookup(19'h00020, 13'h0010, 1'b1, 1'b0);
    expectResp("R3 kernel write allowed", 4'b1000, {19'h00040, 13'h0010});
    doFill(19'h00021, 19'h00041, 1'b0, 4'b0001);
    doLookup(19'h00021, 13'h0020, 1'b0, 1'b1);
    expectResp("R3 user read allowed", 4'b1000, {19'h00041, 13'h0020});
    doLookup(19'h00021, 13'h0020, 1'b1, 1'b1);
    expectResp("R3 user write denied", 4'b0010, '0);
    doLookup(19'h00021, 13'h0020, 1'b0, 1'b0);
    expectResp("R3 kernel read denied", 4'b0010, '0);
  endtask

  task automatic testInvalidate();
    invalidateAll = 1'b1;
    fillValid = 1'b1; fillVpn = 19'h00030; fillPpn = 19'h00050; fillPerm = 4'hF;
    @(posedge clk); @(negedge clk);
    invalidateAll = 1'b0; fillValid = 1'b0;
    doLookup(19'h00011, 13'h0, 1'b0, 1'b1);
    expectResp("R8 old entry gone", 4'b0100, '0);
    doLookup(19'h00030, 13'h0, 1'b0, 1'b1);
    expectResp("R8 fill dropped", 4'b0100, '0);
  endtask

  task automatic testSuper();
    doFill(19'h00125, 19'h03407, 1'b1, 4'hF);
    doLookup(19'h0012B, 13'h1ABC, 1'b0, 1'b1);
    expectResp("R4 R5 superpage mid hit", 4'b1000, {19'h0340B, 13'h1ABC});
    doLookup(19'h00120, 13'h0001, 1'b1, 1'b0);
    expectResp("R4 R5 superpage base", 4'b1000, {19'h03400, 13'h0001});
    doLookup(19'h00130, 13'h0, 1'b0, 1'b1);
    expectResp("R4 above superpage", 4'b0100, '0);
    doLookup(19'h0011F, 13'h0, 1'b0, 1'b1);
    expectResp("R4 below superpage", 4'b0100, '0);
    doFill(19'h0012C, 19'h00009, 1'b0, 4'hF);
    doLookup(19'h0012C, 13'h0, 1'b0, 1'b1);
    expectResp("R9 overlap flagged", 4'b0001, '0);
    doLookup(19'h0012D, 13'h0002, 1'b0, 1'b1);
    expectResp("R4 superpage beside overlap", 4'b1000, {19'h0340D, 13'h0002});
    doInvalidate();
  endtask

  task automatic testLru();
    for (int v = 1; v <= ENTRIES; v++)
      doFill(19'(v), 19'(v + 'h100), 1'b0, 4'b0101);
    doLookup(19'd1, 13'h0, 1'b0, 1'b1);
    doLookup(19'd2, 13'h0, 1'b0, 1'b1);
    doFill(19'd100, 19'h00200, 1'b0, 4'b0101);
    doLookup(19'd4, 13'h0, 1'b1, 1'b1);
    expectResp("R3 write on read-only", 4'b0010, '0);
    doFill(19'd101, 19'h00201, 1'b0, 4'b0101);
    doLookup(19'd3, 13'h0, 1'b0, 1'b1);
    expectResp("R6 oldest evicted", 4'b0100, '0);
    doLookup(19'd4, 13'h0, 1'b0, 1'b1);
    expectResp("R7 fault did not refresh", 4'b0100, '0);
    doLookup(19'd5, 13'h0003, 1'b0, 1'b1);
    expectResp("R6 untouched survivor", 4'b1000, {19'h00105, 13'h0003});
    doLookup(19'd1, 13'h0, 1'b0, 1'b1);
    expectResp("R7 refreshed entry kept", 4'b1000, {19'h00101, 13'h0});
    doLookup(19'd100, 13'h0, 1'b0, 1'b0);
    expectResp("R6 first fill present", 4'b1000, {19'h00200, 13'h0});
    doLookup(19'd101, 13'h0, 1'b0, 1'b0);
    expectResp("R6 second fill present", 4'b1000, {19'h00201, 13'h0});
    doInvalidate();
  endtask

  task automatic testSameCycle();
    lookupValid = 1'b1; lookupVa = {19'h00055, 13'h0007};
    lookupWrite = 1'b0; lookupUser = 1'b1;
    fillValid = 1'b1; fillVpn = 19'h00055; fillPpn = 19'h00077;
    fillSuper = 1'b0; fillPerm = 4'hF;
    @(posedge clk); @(negedge clk);
    lookupValid = 1'b0; fillValid = 1'b0;
    expectResp("R11 lookup sees old table", 4'b0100, '0);
    doLookup(19'h00055, 13'h0007, 1'b0, 1'b1);
    expectResp("R11 fill visible next", 4'b1000, {19'h00077, 13'h0007});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testBasic();
    testPerm();
    testInvalidate();
    testSuper();
    testLru();
    testSameCycle();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(20 * 100000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule